// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between a clocked host and a 128K x 8 asynchronous static RAM. The host raises a request for one byte, read or write, with a 17-bit address. The controller takes it when `ready` is high and then plays out the memory's strobe sequence. Every strobe edge falls on a clock edge, and each phase length is a whole number of clock cycles worked out from the memory's minimum nanosecond timings. A completed read returns its byte with a one-cycle `rsp_valid` pulse.

The memory has two chip selects, one active low and one active high, and it is selected only when both are asserted together. The controller uses each combination of the two for its own purpose. An ordinary access drives both to their active levels. The idle state and the bus turnaround release only the low-active select. The low-power deselect state, entered while `sleep` is high, pulls the high-active select low as well. When `sleep` falls, the controller waits one read-cycle time before it accepts work again. When a write follows a read, it first inserts a few deselected cycles so that the memory has released the shared data bus before the controller turns on its own drivers.

All memory-side outputs come straight from flip-flops, so no strobe passes through decode logic on its way to a pin. The tristate buffer is left to the pad ring, which is why the data bus appears as separate output, output-enable and input vectors.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: Select coding on (`mem_cs1_n`, `mem_cs2`): (0,1) during an access, (1,1) in idle, turnaround and recovery, and (1,0) in deep deselect. Whenever the memory is not selected, `mem_we_n`=1, `mem_oe_n`=1 and `mem_dq_oe`=0.
- R2: `ready` is 1 only in idle with `sleep` low, and it is 1 out of reset. A request is taken on a rising edge where `req` and `ready` are both 1. Address, direction and write data are captured at that edge, and later changes on those inputs have no effect on the transfer.
- R3: A read selects the memory from the edge after acceptance, with `mem_oe_n`=0 and `mem_we_n`=1, for RD_CYC = ceil(T_RC_NS/CLK_NS) cycles (7 at defaults). `mem_addr` holds the captured address throughout. Data is sampled at the edge that ends the last cycle.
- R4: The sampled byte appears on `rsp_data` with `rsp_valid`=1 for exactly the one cycle that follows the read.
- R5: A write selects the memory for WR_CYC = max(ceil(T_WC_NS/CLK_NS), WP_CYC+2) cycles (7 at defaults). During all of them `mem_oe_n`=1, `mem_dq_oe`=1 and `mem_dq_o` equals the captured data.
- R6: `mem_we_n` is 0 for WP_CYC = ceil(T_WP_NS/CLK_NS) consecutive cycles (5 at defaults), starting in the second selected cycle of the write. It is 1 in the first and the last selected cycle.
- R7: A write whose previously accepted transfer was a read is preceded by TURN_CYC = ceil(T_HZ_NS/CLK_NS) cycles (3 at defaults). In these cycles the memory is deselected, all strobes are inactive and the drivers are off. This holds however much idle or sleep time lies between the two transfers. Any other write starts in the cycle after acceptance.
- R8: `mem_dq_oe` is never 1 while `mem_oe_n` is 0.
- R9: `sleep` high in idle brings deep deselect at the next edge. A request is never accepted while `sleep` is high, including a request that arrives in the same cycle as `sleep`.
- R10: `sleep` rising during a transfer leaves that transfer's timing and data intact. Deep deselect follows once the transfer is done.
- R11: Once `sleep` is seen low, the controller stays in recovery, deselected with `mem_cs2`=1 and `ready`=0, for REC_CYC = ceil(T_REC_NS/CLK_NS) cycles (7 at defaults). If `sleep` rises again during recovery, it returns to deep deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep | input | 1 | Low-power deselect request, honoured between transfers |
| req | input | 1 | Host transfer request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write byte |
| ready | output | 1 | Controller can take a request this cycle |
| rsp_data | output | DATA_W | Read byte |
| rsp_valid | output | 1 | One-cycle pulse marking `rsp_data` |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_cs1_n | output | 1 | Memory select, active low |
| mem_cs2 | output | 1 | Memory select, active high |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_o | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the data pad drivers |
| mem_dq_i | input | DATA_W | Data received from the memory |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the sleep request and a host request. The bench raises `sleep` and `req` on the same edge, then holds `req` through the whole sleep. It judges that no strobe moves, that `ready` stays low and that the request is taken only after recovery. The second pair is the sleep request and a transfer already in flight. The bench raises `sleep` in the first cycle of a read and later of a write, then checks that the full strobe pattern and data still come out before deep deselect appears. Constrained random traffic with random sleep breaks covers read-to-write turnaround, and its gap is compared with the previous transfer's direction as the bench recorded it.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_READ  = 3'd1,
      ST_TURN  = 3'd2,
      ST_WRITE = 3'd3,
      ST_SLEEP = 3'd4,
      ST_WAKE  = 3'd5
   } ctl_state_t;

   typedef struct packed {
      logic cs1_n;
      logic cs2;
      logic we_n;
      logic oe_n;
      logic dq_oe;
   } strobe_t;

   localparam strobe_t STB_IDLE  = '{cs1_n: 1'b1, cs2: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
   localparam strobe_t STB_READ  = '{cs1_n: 1'b0, cs2: 1'b1, we_n: 1'b1, oe_n: 1'b0, dq_oe: 1'b0};
   localparam strobe_t STB_WRITE = '{cs1_n: 1'b0, cs2: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b1};
   localparam strobe_t STB_DEEP  = '{cs1_n: 1'b1, cs2: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};

   function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
      return (ns + clk_ns - 1) / clk_ns;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_cyc_timer.sv
module sram_cyc_timer #(
   parameter int unsigned CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt_d,
   output logic             done
);

   logic [CNT_W-1:0] cnt_q;

   always_comb begin
      if (load)
         cnt_d = load_val;
      else if (cnt_q != '0)
         cnt_d = cnt_q - 1'b1;
      else
         cnt_d = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_host_latch.sv
module sram_host_latch #(
   parameter int unsigned ADDR_W = 17,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              capture,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] mem_dq_i,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic [DATA_W-1:0] rdata_q,
   output logic              rvalid_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q   <= '0;
         wdata_q  <= '0;
         rdata_q  <= '0;
         rvalid_q <= 1'b0;
      end else begin
         if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
         end
         if (capture)
            rdata_q <= mem_dq_i;
         rvalid_q <= capture;
      end
   end

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
   import sram_ctrl_pkg::*;
#(
   parameter int unsigned RD_CYC   = 7,
   parameter int unsigned WR_CYC   = 7,
   parameter int unsigned WP_CYC   = 5,
   parameter int unsigned TURN_CYC = 3,
   parameter int unsigned REC_CYC  = 7,
   parameter int unsigned CNT_W    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sleep,
   input  logic             req,
   input  logic             req_wr,
   input  logic [CNT_W-1:0] cnt_d,
   input  logic             done,
   output logic             load,
   output logic [CNT_W-1:0] load_val,
   output logic             ready,
   output logic             accept,
   output logic             capture,
   output strobe_t          strb_q
);

   localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_CYC - 1);
   localparam logic [CNT_W-1:0] WR_LD   = CNT_W'(WR_CYC - 1);
   localparam logic [CNT_W-1:0] REC_LD  = CNT_W'(REC_CYC - 1);
   localparam logic [CNT_W-1:0] TURN_LD = (TURN_CYC > 0) ? CNT_W'(TURN_CYC - 1) : '0;
   localparam logic [CNT_W-1:0] WE_HI   = CNT_W'(WR_CYC - 2);
   localparam logic [CNT_W-1:0] WE_LO   = CNT_W'(WR_CYC - 1 - WP_CYC);

   ctl_state_t st_q, st_d, wr_entry;
   logic       last_rd_q;

   // Variant: with a zero release window a write never needs a turnaround
   if (TURN_CYC > 0) begin : g_turn
      assign wr_entry = last_rd_q ? ST_TURN : ST_WRITE;
   end else begin : g_direct
      assign wr_entry = ST_WRITE;
   end

   assign ready  = (st_q == ST_IDLE) && !sleep;
   assign accept = ready && req;

   function automatic strobe_t decode(input ctl_state_t s, input logic [CNT_W-1:0] c);
      strobe_t o;
      o = STB_IDLE;
      case (s)
         ST_READ:  o = STB_READ;
         ST_WRITE: begin
            o      = STB_WRITE;
            o.we_n = !((c <= WE_HI) && (c >= WE_LO));
         end
         ST_SLEEP: o = STB_DEEP;
         default:  o = STB_IDLE;
      endcase
      return o;
   endfunction

   always_comb begin
      st_d     = st_q;
      load     = 1'b0;
      load_val = '0;
      capture  = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (sleep) begin
               st_d = ST_SLEEP;
            end else if (req) begin
               load = 1'b1;
               if (!req_wr) begin
                  st_d     = ST_READ;
                  load_val = RD_LD;
               end else begin
                  st_d     = wr_entry;
                  load_val = (wr_entry == ST_TURN) ? TURN_LD : WR_LD;
               end
            end
         end
         ST_READ: begin
            if (done) begin
               capture = 1'b1;
               st_d    = ST_IDLE;
            end
         end
         ST_TURN: begin
            if (done) begin
               st_d     = ST_WRITE;
               load     = 1'b1;
               load_val = WR_LD;
            end
         end
         ST_WRITE: begin
            if (done) st_d = ST_IDLE;
         end
         ST_SLEEP: begin
            if (!sleep) begin
               st_d     = ST_WAKE;
               load     = 1'b1;
               load_val = REC_LD;
            end
         end
         ST_WAKE: begin
            if (sleep)     st_d = ST_SLEEP;
            else if (done) st_d = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         last_rd_q <= 1'b0;
         strb_q    <= STB_IDLE;
      end else begin
         st_q   <= st_d;
         strb_q <= decode(st_d, cnt_d);
         if (accept) last_rd_q <= !req_wr;
      end
   end

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int unsigned ADDR_W   = 17,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned CLK_NS   = 10,
   parameter int unsigned T_RC_NS  = 70,
   parameter int unsigned T_WC_NS  = 70,
   parameter int unsigned T_WP_NS  = 50,
   parameter int unsigned T_DW_NS  = 45,
   parameter int unsigned T_AW_NS  = 55,
   parameter int unsigned T_HZ_NS  = 25,
   parameter int unsigned T_REC_NS = 70
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep,
   input  logic              req,
   input  logic              req_wr,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              ready,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_valid,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_cs1_n,
   output logic              mem_cs2,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_i
);

   localparam int unsigned RD_CYC   = ns_to_cyc(T_RC_NS, CLK_NS);
   localparam int unsigned WP_CYC   = ns_to_cyc(T_WP_NS, CLK_NS);
   localparam int unsigned WR_CYC   = umax(ns_to_cyc(T_WC_NS, CLK_NS), WP_CYC + 2);
   localparam int unsigned TURN_CYC = ns_to_cyc(T_HZ_NS, CLK_NS);
   localparam int unsigned REC_CYC  = umax(ns_to_cyc(T_REC_NS, CLK_NS), 1);
   localparam int unsigned MAX_CYC  = umax(umax(RD_CYC, WR_CYC), umax(TURN_CYC, REC_CYC));
   localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

   // Elaboration-time parameter checks
   initial begin : p_param_check
      assert (CLK_NS > 0 && ADDR_W > 0 && DATA_W > 0)
         else $error("sram_strobe_ctrl: zero clock period or width");
      assert (RD_CYC >= 1)
         else $error("sram_strobe_ctrl: read phase must span a cycle");
      assert ((WP_CYC + 1) * CLK_NS >= T_AW_NS)
         else $error("sram_strobe_ctrl: select/address window before write end too short");
      assert ((WP_CYC + 1) * CLK_NS >= T_DW_NS)
         else $error("sram_strobe_ctrl: data setup before write end too short");
      assert (WR_CYC * CLK_NS >= T_WC_NS)
         else $error("sram_strobe_ctrl: write cycle too short");
   end

   logic             load, done, accept, capture;
   logic [CNT_W-1:0] load_val, cnt_d;
   strobe_t          strb;

   sram_cyc_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_val),
      .cnt_d    (cnt_d),
      .done     (done)
   );

   sram_seq_fsm #(
      .RD_CYC   (RD_CYC),
      .WR_CYC   (WR_CYC),
      .WP_CYC   (WP_CYC),
      .TURN_CYC (TURN_CYC),
      .REC_CYC  (REC_CYC),
      .CNT_W    (CNT_W)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .sleep    (sleep),
      .req      (req),
      .req_wr   (req_wr),
      .cnt_d    (cnt_d),
      .done     (done),
      .load     (load),
      .load_val (load_val),
      .ready    (ready),
      .accept   (accept),
      .capture  (capture),
      .strb_q   (strb)
   );

   sram_host_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .capture   (capture),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .mem_dq_i  (mem_dq_i),
      .addr_q    (mem_addr),
      .wdata_q   (mem_dq_o),
      .rdata_q   (rsp_data),
      .rvalid_q  (rsp_valid)
   );

   assign mem_cs1_n = strb.cs1_n;
   assign mem_cs2   = strb.cs2;
   assign mem_we_n  = strb.we_n;
   assign mem_oe_n  = strb.oe_n;
   assign mem_dq_oe = strb.dq_oe;

endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
module sram_strobe_ctrl_chk #(
   parameter int unsigned ADDR_W = 17,
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sleep,
   input logic              ready,
   input logic              rsp_valid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_cs1_n,
   input logic              mem_cs2,
   input logic              mem_we_n,
   input logic              mem_oe_n,
   input logic [DATA_W-1:0] mem_dq_o,
   input logic              mem_dq_oe
);

   a_r1_write_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_cs1_n && mem_cs2));

   a_r1_deep_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_cs2 |-> (mem_cs1_n && mem_we_n && mem_oe_n && !mem_dq_oe));

   a_r2_ready_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (mem_cs1_n && mem_we_n && mem_oe_n && !mem_dq_oe));

   a_r3_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_cs1_n && $past(!mem_cs1_n)) |-> $stable(mem_addr));

   a_r4_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   a_r4_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(!mem_oe_n));

   a_r6_data_under_we: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (mem_dq_oe && mem_oe_n));

   a_r6_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_dq_o)));

   a_r8_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);

   a_r9_deep_from_sleep: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_cs2) |-> $past(sleep));

endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sleep     (sleep),
   .ready     (ready),
   .rsp_valid (rsp_valid),
   .mem_addr  (mem_addr),
   .mem_cs1_n (mem_cs1_n),
   .mem_cs2   (mem_cs2),
   .mem_we_n  (mem_we_n),
   .mem_oe_n  (mem_oe_n),
   .mem_dq_o  (mem_dq_o),
   .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_strobe_ctrl_test.sv
module sram_strobe_ctrl_test;

   function automatic int cdiv(input int n, input int c);
      return (n + c - 1) / c;
   endfunction
   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   localparam int CLK  = 8;
   localparam int RD   = cdiv(70, CLK);
   localparam int WP   = cdiv(50, CLK);
   localparam int WR   = imax(cdiv(70, CLK), WP + 2);
   localparam int TURN = cdiv(25, CLK);
   localparam int REC  = cdiv(70, CLK);
   localparam int WIN  = TURN + imax(RD, WR) + 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sleep = 1'b0;
   logic        req = 1'b0;
   logic        req_wr = 1'b0;
   logic [16:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        ready, rsp_valid, mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [7:0]  rsp_data, mem_dq_o, mem_dq_i;
   logic [16:0] mem_addr;

   always #4 clk = ~clk;

   sram_strobe_ctrl #(.CLK_NS(CLK)) uut (
      .clk(clk), .rst_n(rst_n), .sleep(sleep), .req(req), .req_wr(req_wr),
      .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
      .rsp_data(rsp_data), .rsp_valid(rsp_valid), .mem_addr(mem_addr),
      .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2), .mem_we_n(mem_we_n),
      .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
      .mem_dq_i(mem_dq_i)
   );

   // Small behavioural memory, indexed by the low address byte
   logic [7:0] sram    [256];
   logic [7:0] exp_mem [256];
   wire mem_sel = (mem_cs1_n === 1'b0) && (mem_cs2 === 1'b1);

   always @(posedge mem_we_n)
      if (mem_sel && mem_dq_oe === 1'b1) sram[mem_addr[7:0]] <= mem_dq_o;

   assign mem_dq_i = (mem_sel && !mem_oe_n && mem_we_n) ? sram[mem_addr[7:0]] : 8'hA5;

   int n_chk = 0, n_fail = 0, contention = 0;
   bit last_rd = 1'b0;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
   endtask

   always @(negedge clk)
      if (rst_n && mem_dq_oe && !mem_oe_n) contention++;

   task automatic issue(input bit w, input logic [16:0] a, input logic [7:0] d);
      while (!ready) @(negedge clk);
      req = 1'b1; req_wr = w; req_addr = a; req_wdata = d;
      @(negedge clk);
      req = 1'b0; req_wr = ~w; req_addr = ~a; req_wdata = ~d;
   endtask

   task automatic observe(input bit w, input logic [16:0] a, input logic [7:0] d,
                          input int exp_gap, input bit chk_rdy);
      int gap = 0, sel_n = 0, we_cnt = 0, we_first = -1, we_last = -1, oe_cnt = 0;
      int drv = 0, rv = 0, rdy_low = 0, addr_bad = 0, data_bad = 0, stb_bad = 0;
      int got = 0;
      bit seen = 1'b0;
      for (int k = 0; k < WIN; k++) begin
         if (mem_cs1_n == 1'b0 && mem_cs2 == 1'b1) begin
            seen = 1'b1;
            if (mem_addr != a) addr_bad++;
            if (!mem_we_n) begin
               if (we_first < 0) we_first = sel_n;
               we_last = sel_n;
               we_cnt++;
            end
            if (!mem_oe_n) oe_cnt++;
            if (mem_dq_oe) begin
               drv++;
               if (mem_dq_o != d) data_bad++;
            end
            sel_n++;
         end else begin
            if (!seen) gap++;
            if (!mem_we_n || !mem_oe_n || mem_dq_oe) stb_bad++;
         end
         if (rsp_valid) begin rv++; got = int'(rsp_data); end
         if (!ready) rdy_low++;
         @(negedge clk);
      end
      chk("R1 strobes active while deselected", stb_bad, 0);
      chk("R3 address bus vs captured address", addr_bad, 0);
      if (w) begin
         chk("R7 turnaround cycles", gap, exp_gap);
         chk("R5 selected cycles of write", sel_n, WR);
         chk("R5 driver-enable cycles", drv, WR);
         chk("R5 output-enable low in write", oe_cnt, 0);
         chk("R5 driven data mismatches", data_bad, 0);
         chk("R5 no read pulse on write", rv, 0);
         chk("R6 write-enable low cycles", we_cnt, WP);
         chk("R6 first write-enable low index", we_first, 1);
         chk("R6 last write-enable low index", we_last, WP);
         exp_mem[a[7:0]] = d;
      end else begin
         chk("R3 selected cycles of read", sel_n, RD);
         chk("R3 output-enable low cycles", oe_cnt, RD);
         chk("R3 write-enable low in read", we_cnt, 0);
         chk("R8 driver on during read", drv, 0);
         chk("R4 valid pulses", rv, 1);
         chk("R4 read data", got, int'(exp_mem[a[7:0]]));
      end
      if (chk_rdy) chk("R2 ready low cycles", rdy_low, exp_gap + (w ? WR : RD));
   endtask

   task automatic xfer(input bit w, input logic [16:0] a, input logic [7:0] d);
      int g;
      g = (w && last_rd) ? TURN : 0;
      issue(w, a, d);
      observe(w, a, d, g, 1'b1);
      last_rd = !w;
   endtask

   task automatic wake_check();
      int n = 0, bad = 0;
      sleep = 1'b0;
      @(negedge clk);
      while (!ready && n < 100) begin
         if (!(mem_cs1_n == 1'b1 && mem_cs2 == 1'b1)) bad++;
         n++;
         @(negedge clk);
      end
      chk("R11 recovery cycles", n, REC);
      chk("R11 recovery select levels", bad, 0);
   endtask

   task automatic sleep_cycle(input int hold);
      int bad = 0;
      sleep = 1'b1;
      #1;
      chk("R9 ready drops with sleep", int'(ready), 0);
      @(negedge clk);
      for (int k = 0; k < hold; k++) begin
         if (!(mem_cs1_n && !mem_cs2 && mem_we_n && mem_oe_n && !mem_dq_oe)) bad++;
         @(negedge clk);
      end
      chk("R9 deep deselect levels", bad, 0);
      wake_check();
   endtask

   initial begin
      for (int i = 0; i < 256; i++) begin sram[i] = 8'h00; exp_mem[i] = 8'h00; end
      void'($urandom(32'd7321));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // Reset state
      chk("R2 ready after reset", int'(ready), 1);
      chk("R1 idle select pair", int'({mem_cs1_n, mem_cs2}), 3);
      chk("R1 idle strobes", int'({mem_we_n, mem_oe_n, mem_dq_oe}), 6);
      chk("R4 no valid after reset", int'(rsp_valid), 0);

      // Directed: first write, write-write, read-back, read-read, turnaround
      xfer(1'b1, 17'h00000, 8'h3C);
      xfer(1'b1, 17'h1FFFF, 8'hC3);
      xfer(1'b0, 17'h00000, 8'h00);
      xfer(1'b0, 17'h1FFFF, 8'h00);
      xfer(1'b1, 17'h10055, 8'h96);
      xfer(1'b0, 17'h10055, 8'h00);

      // R9: sleep and request in the same cycle; request waits for recovery
      begin
         int bad = 0;
         req = 1'b1; req_wr = 1'b0; req_addr = 17'h000FF; sleep = 1'b1;
         #1;
         chk("R9 same-cycle ready", int'(ready), 0);
         for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (mem_cs1_n != 1'b1 || mem_cs2 != 1'b0) bad++;
         end
         chk("R9 request held off during sleep", bad, 0);
         sleep = 1'b0;
         while (!ready) @(negedge clk);
         @(negedge clk);
         req = 1'b0;
         observe(1'b0, 17'h000FF, 8'h00, 0, 1'b1);
         last_rd = 1'b1;
      end

      // R10: sleep raised during a read, then during a write after it
      issue(1'b0, 17'h1FFFF, 8'h00);
      sleep = 1'b1;
      observe(1'b0, 17'h1FFFF, 8'h00, 0, 1'b0);
      chk("R10 deep deselect after read", int'(mem_cs2), 0);
      wake_check();
      issue(1'b1, 17'h0AA01, 8'h5A);
      sleep = 1'b1;
      observe(1'b1, 17'h0AA01, 8'h5A, TURN, 1'b0);
      chk("R10 deep deselect after write", int'(mem_cs2), 0);
      last_rd = 1'b0;
      wake_check();
      xfer(1'b0, 17'h0AA01, 8'h00);

      // Constrained random traffic with occasional sleep breaks
      for (int i = 0; i < 80; i++) begin
         logic [16:0] a;
         logic [7:0]  d;
         bit w;
         w = ($urandom % 100) < 50;
         a = {9'($urandom), 8'($urandom % 16)};
         d = 8'($urandom);
         xfer(w, a, d);
         if (($urandom % 8) == 0) sleep_cycle(1 + int'($urandom % 4));
         else repeat ($urandom % 3) @(negedge clk);
      end

      chk("R8 contention cycles", contention, 0);
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

endmodule